// File: doc/BRIEF.md
# Serial EEPROM Status and Write-Guard Controller

This block holds the status byte of a serial EEPROM and decides which writes may proceed. It keeps a write-enable latch, a busy flag for the self-timed programming cycle, a two-bit block-protect code and a bit that arms the external write-protect pin. The serial front end decodes each command and sends this block one-cycle event pulses. A pulse is sent when chip select rises after a complete enable, disable, status-write or array-write sequence.

From these events and the write-protect pin level, the block produces four outputs. The status byte that a status read shifts out. A busy flag. A per-address permit for the array byte that the front end is about to commit. A permit for status writes. An accepted status or array write starts a programming cycle of a fixed number of system clocks. At the end of that cycle the write-enable latch is cleared. The nonvolatile bits are plain registers that a power-on reset clears.

The front end sends at most one event per clock. It commits array bytes only when the address permit is high.

Top module: `eeprom_guard`

## Requirements
- R1: After reset the status byte, busy, the address permit and the status-write permit are all 0.
- R2: When not busy, an enable event sets the latch (status bit 1) and a disable event clears it. Both take effect whether or not the status register is locked.
- R3: An accepted status write stores data bit 7 as the pin-arm bit (status bit 7) and data bits 3:2 as the block-protect code (status bits 3:2). Status bits 6:4 always read 0. Data bits 6:4, 1 and 0 are discarded.
- R4: With the latch set and not busy, the address permit for a 15-bit address depends on the protect code. Code 00 protects nothing. Code 01 protects 6000h-7FFFh. Code 10 protects 4000h-7FFFh. Code 11 protects everything.
- R5: The address permit and the status-write permit are 0 whenever the latch is clear or the block is busy.
- R6: The status register is locked when status bit 7 is 1 and the pin input is low. A status write while locked changes nothing and starts no cycle. Array permits are unaffected by the lock.
- R7: An accepted status write, or an array-write event with the latch set, raises busy (status bit 0) on the next cycle. Busy stays high for exactly CYCLE_CLKS cycles.
- R8: When a programming cycle ends, the latch is cleared.
- R9: Enable, disable, status-write and array-write events that arrive while busy are ignored.
- R10: A change on the pin input during a cycle alters neither the cycle length nor the stored status bits.
- R11: An array-write event with the latch clear starts no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| cmd_set_wel | input | 1 | Enable-latch command completed (pulse) |
| cmd_clr_wel | input | 1 | Disable-latch command completed (pulse) |
| cmd_sr_commit | input | 1 | Status write sequence completed (pulse) |
| cmd_arr_commit | input | 1 | Array write sequence completed (pulse) |
| sr_din | input | 8 | Data byte of the status write |
| wp_pin_hi | input | 1 | Level of the write-protect pin, 1 = high |
| probe_addr | input | ADDR_W | Array byte address under test |
| status_q | output | 8 | Status byte |
| busy | output | 1 | Programming cycle in progress |
| probe_addr_ok | output | 1 | Write to probe_addr is permitted |
| sr_write_ok | output | 1 | Status write is permitted |

## Verification
Assertions check on every cycle that:
- an accepted start raises busy on the next cycle;
- busy lasts exactly the programmed number of clocks;
- the latch is clear after every cycle end;
- the latch and the stored bits stay frozen during a cycle;
- a locked status write leaves the stored bits alone.

The exact mapping of the protect codes onto address ranges, and the discarding of unused data bits, can only be shown by the bench's scenarios. So can the independence of the lock from array permits and the effect of toggling the pin during a cycle. For these the bench compares against its own model and uses directed probes at the range edges.

// File: rtl/guard_pkg.sv
package guard_pkg;

  localparam int unsigned SR_W = 8;

  typedef struct packed {
    logic       wpen;
    logic [1:0] bp;
  } nv_bits_t;

  // Assemble the visible status byte; bits 6..4 are reserved zero.
  function automatic logic [SR_W-1:0] pack_status(nv_bits_t nv, logic wel, logic wip);
    logic [SR_W-1:0] s;
    s      = '0;
    s[7]   = nv.wpen;
    s[3:2] = nv.bp;
    s[1]   = wel;
    s[0]   = wip;
    return s;
  endfunction

  // Status register is locked when the pin is armed and driven low.
  function automatic logic sr_locked(logic wpen, logic wp_hi);
    return wpen & ~wp_hi;
  endfunction

endpackage

// File: rtl/guard_block_map.sv
module guard_block_map #(
  parameter int unsigned ADDR_W = 15
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        bp,
  output logic              hit
);
  // Protection decodes only the two top address bits (quarters of the array).
  function automatic logic in_guarded(logic [1:0] top2, logic [1:0] code);
    case (code)
      2'b00:   return 1'b0;
      2'b01:   return top2 == 2'b11;
      2'b10:   return top2[1];
      default: return 1'b1;
    endcase
  endfunction

  assign hit = in_guarded(addr[ADDR_W-1 -: 2], bp);

endmodule

// File: rtl/guard_cycle_timer.sv
module guard_cycle_timer #(
  parameter int unsigned CYCLE_CLKS = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int unsigned      CW   = $clog2(CYCLE_CLKS + 1);
  localparam logic [CW-1:0]    LAST = CW'(CYCLE_CLKS - 1);

  logic [CW-1:0] remain;
  logic [CW-1:0] run_len;

  assign done = busy && (remain == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      remain <= '0;
    end else if (start && !busy) begin
      busy   <= 1'b1;
      remain <= LAST;
    end else if (done) begin
      busy   <= 1'b0;
    end else if (busy) begin
      remain <= remain - 1'b1;
    end
  end

  // Independent up-counter of elapsed busy cycles, used by the checks below.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     run_len <= '0;
    else if (!busy) run_len <= '0;
    else            run_len <= run_len + 1'b1;
  end

  AST_CYCLE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> run_len == LAST); // R7
  AST_NO_EARLY_END: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy); // R7

endmodule

// File: rtl/guard_status_reg.sv
module guard_status_reg
  import guard_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_set_wel,
  input  logic       cmd_clr_wel,
  input  logic       cmd_sr_commit,
  input  logic       cmd_arr_commit,
  input  logic       din_wpen,
  input  logic [1:0] din_bp,
  input  logic       wp_pin_hi,
  input  logic       busy,
  input  logic       done,
  output nv_bits_t   nv,
  output logic       wel,
  output logic       locked,
  output logic       start
);
  logic acc_set, acc_clr, acc_sr, acc_arr;

  assign locked  = sr_locked(nv.wpen, wp_pin_hi);
  assign acc_set = cmd_set_wel && !busy;
  assign acc_clr = cmd_clr_wel && !busy;
  assign acc_sr  = cmd_sr_commit && !busy && wel && !locked;
  assign acc_arr = cmd_arr_commit && !busy && wel;
  assign start   = acc_sr || acc_arr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wel <= 1'b0;
    else if (done)    wel <= 1'b0;
    else if (acc_clr) wel <= 1'b0;
    else if (acc_set) wel <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      nv <= '0;
    else if (acc_sr) nv <= '{wpen: din_wpen, bp: din_bp};
  end

  AST_WEL_CLR_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !wel); // R8
  AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> ($stable(wel) && $stable(nv))); // R9
  AST_LOCK_KEEPS_NV: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_sr_commit && locked) |=> $stable(nv)); // R6
  AST_LOCK_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_sr_commit && locked && !busy && !cmd_arr_commit) |=> !busy); // R6

endmodule

// File: rtl/eeprom_guard.sv
module eeprom_guard
  import guard_pkg::*;
#(
  parameter int unsigned ADDR_W     = 15,
  parameter int unsigned CYCLE_CLKS = 500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_set_wel,
  input  logic              cmd_clr_wel,
  input  logic              cmd_sr_commit,
  input  logic              cmd_arr_commit,
  input  logic [SR_W-1:0]   sr_din,
  input  logic              wp_pin_hi,
  input  logic [ADDR_W-1:0] probe_addr,
  output logic [SR_W-1:0]   status_q,
  output logic              busy,
  output logic              probe_addr_ok,
  output logic              sr_write_ok
);
  nv_bits_t nv;
  logic     wel, locked, start_cyc, cyc_done, block_hit;
  logic     unused_din_bits;

  assign unused_din_bits = ^{sr_din[6:4], sr_din[1:0]};

  guard_status_reg u_status (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmd_set_wel    (cmd_set_wel),
    .cmd_clr_wel    (cmd_clr_wel),
    .cmd_sr_commit  (cmd_sr_commit),
    .cmd_arr_commit (cmd_arr_commit),
    .din_wpen       (sr_din[7]),
    .din_bp         (sr_din[3:2]),
    .wp_pin_hi      (wp_pin_hi),
    .busy           (busy),
    .done           (cyc_done),
    .nv             (nv),
    .wel            (wel),
    .locked         (locked),
    .start          (start_cyc)
  );

  guard_cycle_timer #(.CYCLE_CLKS(CYCLE_CLKS)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start_cyc),
    .busy  (busy),
    .done  (cyc_done)
  );

  guard_block_map #(.ADDR_W(ADDR_W)) u_map (
    .addr (probe_addr),
    .bp   (nv.bp),
    .hit  (block_hit)
  );

  assign status_q      = pack_status(nv, wel, busy);
  assign probe_addr_ok = wel && !busy && !block_hit;
  assign sr_write_ok   = wel && !busy && !locked;

  AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_cyc |=> busy); // R7
  AST_END_DROPS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !status_q[1]); // R8

endmodule

// File: tb/tb_eeprom_guard.sv
module tb_eeprom_guard;
  localparam int CLK_PER = 10;
  localparam int CYC     = 12;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        cmd_set_wel = 0, cmd_clr_wel = 0, cmd_sr_commit = 0, cmd_arr_commit = 0;
  logic [7:0]  sr_din = 0;
  logic        wp_pin_hi = 1;
  logic [14:0] probe_addr = 0;
  logic [7:0]  status_q;
  logic        busy, probe_addr_ok, sr_write_ok;

  int    n_chk = 0, n_err = 0;
  bit    finished = 0;
  string cur_req = "R1";

  // reference model state
  int m_wel = 0, m_wip = 0, m_wpen = 0, m_bp = 0, m_left = 0;

  always #(CLK_PER/2) clk = ~clk;

  eeprom_guard #(.ADDR_W(15), .CYCLE_CLKS(CYC)) dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_set_wel(cmd_set_wel), .cmd_clr_wel(cmd_clr_wel),
    .cmd_sr_commit(cmd_sr_commit), .cmd_arr_commit(cmd_arr_commit),
    .sr_din(sr_din), .wp_pin_hi(wp_pin_hi), .probe_addr(probe_addr),
    .status_q(status_q), .busy(busy),
    .probe_addr_ok(probe_addr_ok), .sr_write_ok(sr_write_ok)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int m_status();
    return (m_wpen << 7) | (m_bp << 2) | (m_wel << 1) | m_wip;
  endfunction

  function automatic int m_addr_ok(int a);
    if (m_wel == 0 || m_wip == 1) return 0;
    case (m_bp)
      0: return 1;
      1: return (a < 24576) ? 1 : 0;
      2: return (a < 16384) ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  function automatic int m_sr_ok();
    if (m_wel == 0 || m_wip == 1) return 0;
    return (m_wpen == 1 && wp_pin_hi == 0) ? 0 : 1;
  endfunction

  // behavioural model, one step per rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_wel = 0; m_wip = 0; m_wpen = 0; m_bp = 0; m_left = 0;
    end else if (m_wip == 1) begin
      if (m_left == 1) begin m_wip = 0; m_wel = 0; end
      else m_left = m_left - 1;
    end else begin
      if (cmd_clr_wel) m_wel = 0;
      else if (cmd_set_wel) m_wel = 1;
      else if (cmd_sr_commit) begin
        if (m_wel == 1 && !(m_wpen == 1 && wp_pin_hi == 0)) begin
          m_wpen = sr_din[7]; m_bp = sr_din[3:2]; m_wip = 1; m_left = CYC;
        end
      end else if (cmd_arr_commit && m_wel == 1) begin
        m_wip = 1; m_left = CYC;
      end
    end
  end

  // compare against the model every cycle, a quarter period after the edge
  always @(posedge clk) begin
    #(CLK_PER/4);
    if (rst_n && !finished) begin
      check({cur_req, " model status"}, status_q, m_status());
      check({cur_req, " model busy"}, busy, m_wip);
      check({cur_req, " model addr permit"}, probe_addr_ok, m_addr_ok(probe_addr));
      check({cur_req, " model status permit"}, sr_write_ok, m_sr_ok());
    end
  end

  // which: 0 enable, 1 disable, 2 status write, 3 array write
  task automatic pulse(input int which, input logic [7:0] d);
    @(negedge clk);
    sr_din = d;
    case (which)
      0: cmd_set_wel = 1;
      1: cmd_clr_wel = 1;
      2: cmd_sr_commit = 1;
      default: cmd_arr_commit = 1;
    endcase
    @(negedge clk);
    cmd_set_wel = 0; cmd_clr_wel = 0; cmd_sr_commit = 0; cmd_arr_commit = 0;
    #(CLK_PER/8);
  endtask

  task automatic set_probe(input logic [14:0] a);
    @(negedge clk);
    probe_addr = a;
    #(CLK_PER/8);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    #(CLK_PER/8);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #(CLK_PER/8);
    cur_req = "R1";
    check("R1 reset status", status_q, 0);
    check("R1 reset busy", busy, 0);
    check("R1 reset addr permit", probe_addr_ok, 0);
    check("R1 reset status permit", sr_write_ok, 0);

    cur_req = "R11";
    pulse(3, 8'h00);
    check("R11 array write without latch busy", busy, 0);
    check("R11 array write without latch status", status_q, 8'h00);

    cur_req = "R2";
    set_probe(15'h7FFF);
    pulse(0, 8'h00);
    check("R2 enable sets latch", status_q, 8'h02);
    check("R4 code 00 top address permitted", probe_addr_ok, 1);
    check("R5 status permit with latch", sr_write_ok, 1);
    pulse(1, 8'h00);
    check("R2 disable clears latch", status_q, 8'h00);
    check("R5 no addr permit without latch", probe_addr_ok, 0);

    cur_req = "R3";
    pulse(0, 8'h00);
    pulse(2, 8'hF7);
    check("R3 stored bits and busy, unused zero", status_q, 8'h87);
    check("R5 no addr permit while busy", probe_addr_ok, 0);
    check("R5 no status permit while busy", sr_write_ok, 0);
    cur_req = "R7";
    n = 0;
    while (busy) begin n++; @(negedge clk); #(CLK_PER/8); end
    check("R7 busy length", n, CYC);
    check("R8 latch cleared at cycle end", status_q, 8'h84);

    cur_req = "R4";
    pulse(0, 8'h00);
    set_probe(15'h5FFF);
    check("R4 code 01 below 6000h permitted", probe_addr_ok, 1);
    set_probe(15'h6000);
    check("R4 code 01 6000h protected", probe_addr_ok, 0);
    pulse(2, 8'h88);
    wait_idle();
    pulse(0, 8'h00);
    set_probe(15'h3FFF);
    check("R4 code 10 below 4000h permitted", probe_addr_ok, 1);
    set_probe(15'h4000);
    check("R4 code 10 4000h protected", probe_addr_ok, 0);
    pulse(2, 8'h8C);
    wait_idle();
    pulse(0, 8'h00);
    set_probe(15'h0000);
    check("R4 code 11 address 0 protected", probe_addr_ok, 0);
    pulse(2, 8'h80);
    wait_idle();
    pulse(0, 8'h00);
    set_probe(15'h7FFF);
    check("R4 code 00 7FFFh permitted", probe_addr_ok, 1);

    cur_req = "R6";
    @(negedge clk); wp_pin_hi = 0; #(CLK_PER/8);
    check("R6 locked status permit", sr_write_ok, 0);
    check("R6 lock leaves array permit", probe_addr_ok, 1);
    pulse(2, 8'h0C);
    check("R6 locked write no busy", busy, 0);
    check("R6 locked write keeps status", status_q, 8'h82);
    cur_req = "R2";
    pulse(1, 8'h00);
    check("R2 disable works under lock", status_q, 8'h80);
    pulse(0, 8'h00);
    check("R2 enable works under lock", status_q, 8'h82);

    cur_req = "R9";
    set_probe(15'h0100);
    pulse(3, 8'h00);
    check("R7 array write starts cycle", status_q, 8'h83);
    pulse(1, 8'h00);
    check("R9 disable ignored while busy", status_q, 8'h83);
    cur_req = "R10";
    @(negedge clk); wp_pin_hi = 1; #(CLK_PER/8);
    pulse(2, 8'h0C);
    check("R9 status write ignored while busy", status_q, 8'h83);
    check("R10 pin change keeps cycle running", busy, 1);
    wait_idle();
    check("R10 stored bits unchanged after cycle", status_q, 8'h80);

    cur_req = "R6";
    @(negedge clk); wp_pin_hi = 0; #(CLK_PER/8);
    pulse(0, 8'h00);
    check("R6 array permit independent of lock", probe_addr_ok, 1);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(CLK_PER * 200000);
    if (!finished) begin
      finished = 1;
      n_err++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule